// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Divider

This block turns a digitized VCO clock into a low-rate comparison pulse for a phase detector. Every input clock edge counts once. At the end of each division period the block emits a pulse that is one cycle wide. The total division ratio comes from an 8-bit main value and a 6-bit swallow value.

In the swallow modes, a prescaler divides by either the base modulus or the base modulus plus one. A swallow counter, loaded at the start of each period, selects which. A main counter ends the period after its value plus one prescaler cycles. The base modulus is normally 64. When the half-step input is set, the base modulus is 32 and the swallow value loses its top bit. In direct mode, the two values are joined into one 14-bit count. A standby setting halts all division at once.

The main and swallow values and the mode are captured only at a period boundary. A period that has already started always completes with the settings it started with. A configuration flag reports settings that break the swallow rules. Even then, the divider still runs with a period that is fully defined.

Top module: `vco_swallow_div`

## Requirements
- R1: While reset is high, and after it is released, `syn_pulse` and `cfg_err` are 0.
- R2: Full swallow (mode 01 or 10, `half_step`=0). Let B=`pc_val` and A=`sc_val`, with A≤B+1. The period is (B+1) prescaler cycles. The first A cycles are 65 clocks long and the rest are 64 clocks long, so the ratio is 64·B+A+64.
- R3: Half swallow (mode 01 or 10, `half_step`=1). A=`sc_val[4:0]` and the ratio is 32·B+A+32. `sc_val[5]` has no effect on the period, but when it is set it raises `cfg_err`.
- R4: Direct mode (mode 11). C={`pc_val`,`sc_val`}, with `pc_val` as the upper bits. The period is C+1 clocks, and `half_step` has no effect. With C=0 the pulse is high on every cycle.
- R5: Standby (mode 00). No pulse appears and `cfg_err` is 0 from the first edge that sees the mode. When leaving standby, the first edge that sees the new mode starts a period. The first pulse is then high after the edge N clocks later, where N is the ratio.
- R6: Changes to `pc_val`, `sc_val`, `half_step` or the swallow/direct choice take effect only at the next period boundary. The period in progress is never shortened or lengthened.
- R7: In a swallow mode, `cfg_err` is 1 when B<A or B is below the base modulus (64 or 32). When A>B+1, all B+1 prescaler cycles use the base modulus plus one.
- R8: In the swallow modes, `syn_pulse` is high for exactly one clock per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digitized VCO clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 00 standby, 01 FM swallow, 10 AM swallow, 11 AM direct |
| half_step | input | 1 | Selects the 32/33 prescaler in the swallow modes |
| pc_val | input | 8 | Main counter value (upper part of C in direct mode) |
| sc_val | input | 6 | Swallow value (lower part of C in direct mode) |
| syn_pulse | output | 1 | One pulse per division period |
| cfg_err | output | 1 | Captured settings break the swallow rules |

## Verification
After a standby gap, the edge that sees the new settings loads the period. The pulse is high at the first falling edge after the edge N clocks later. The bench counts falling edges from the one where it drives the settings, and expects N+1. Between pulses it expects exactly N falling edges. `cfg_err` is registered on the load edge, so it is checked together with the first pulse. The effects of standby are due one edge after the mode is applied, and they are sampled at the next falling edge.

// File: rtl/svd_pkg.sv
package svd_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE   = 2'b00,
      MODE_FM_SW  = 2'b01,
      MODE_AM_SW  = 2'b10,
      MODE_AM_DIR = 2'b11
   } div_mode_e;

   function automatic logic mode_is_swallow(input logic [1:0] m);
      return (m == MODE_FM_SW) || (m == MODE_AM_SW);
   endfunction

endpackage

// File: rtl/svd_prescaler.sv
module svd_prescaler #(
   parameter int BASE_LOG2 = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic load,
   input  logic half,
   input  logic plus_one,
   output logic tick
);
   localparam int CW   = BASE_LOG2 + 1;
   localparam int FULL = 1 << BASE_LOG2;
   localparam int HALF = FULL / 2;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] reload_v;

   always_comb begin
      reload_v = (half ? CW'(HALF) : CW'(FULL)) - CW'(1) + CW'(plus_one);
      tick     = run && (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (rst)                     cnt_q <= '0;
      else if (load)               cnt_q <= reload_v;
      else if (run && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
   end
endmodule

// File: rtl/svd_swallow_ctl.sv
module svd_swallow_ctl #(
   parameter int PC_W = 8,
   parameter int SC_W = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            tick,
   input  logic [SC_W-1:0] a_init,
   input  logic [PC_W-1:0] b_init,
   output logic            done,
   output logic            plus_next
);
   logic [SC_W-1:0] a_q, a_dec;
   logic [PC_W-1:0] b_q;

   always_comb begin
      a_dec     = (a_q != '0) ? a_q - SC_W'(1) : a_q;
      done      = tick && (b_q == '0);
      plus_next = start ? (a_init != '0) : (a_dec != '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else if (start) begin
         a_q <= a_init;
         b_q <= b_init;
      end else if (tick) begin
         a_q <= a_dec;
         b_q <= b_q - PC_W'(1);
      end
   end
endmodule

// File: rtl/svd_direct_cnt.sv
module svd_direct_cnt #(
   parameter int C_W = 14
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  logic           run,
   input  logic [C_W-1:0] c_init,
   output logic           done
);
   logic [C_W-1:0] cnt_q;

   assign done = run && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)                     cnt_q <= '0;
      else if (start)              cnt_q <= c_init;
      else if (run && cnt_q != '0) cnt_q <= cnt_q - C_W'(1);
   end
endmodule

// File: rtl/vco_swallow_div.sv
module vco_swallow_div #(
   parameter int PC_W      = 8,
   parameter int SC_W      = 6,
   parameter int BASE_LOG2 = 6,
   parameter bit HAS_HALF  = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      mode_sel,
   input  logic            half_step,
   input  logic [PC_W-1:0] pc_val,
   input  logic [SC_W-1:0] sc_val,
   output logic            syn_pulse,
   output logic            cfg_err
);
   import svd_pkg::*;

   localparam int C_W  = PC_W + SC_W;
   localparam int FULL = 1 << BASE_LOG2;
   localparam int HALF = FULL / 2;

   if (SC_W != BASE_LOG2) begin : g_bad_sc
      $error("swallow width must match prescaler base");
   end
   if (PC_W <= BASE_LOG2) begin : g_bad_pc
      $error("main counter too narrow to reach base modulus");
   end

   logic stby, live_sw, live_dir, half_eff, err_live;
   logic [SC_W-1:0] a_live;
   logic arm_q, sw_q, half_q;
   logic run, start, sw_start, dir_start, period_end;
   logic pre_tick, pre_load, pre_half, plus_next, sw_done, dir_done;

   if (HAS_HALF) begin : g_half
      assign half_eff = half_step;
      assign a_live   = half_step ? {1'b0, sc_val[SC_W-2:0]} : sc_val;
   end else begin : g_full_only
      assign half_eff = 1'b0;
      assign a_live   = sc_val;
   end

   always_comb begin
      stby     = (mode_sel == MODE_IDLE);
      live_sw  = mode_is_swallow(mode_sel);
      live_dir = (mode_sel == MODE_AM_DIR);
      err_live = live_sw && ((int'(pc_val) < int'(a_live)) ||
                             (int'(pc_val) < (half_eff ? HALF : FULL)) ||
                             (half_eff && sc_val[SC_W-1]));
      run        = !stby && !arm_q;
      period_end = run && (sw_q ? sw_done : dir_done);
      start      = !stby && (arm_q || period_end);
      sw_start   = start && live_sw;
      dir_start  = start && live_dir;
      pre_load   = sw_start || (pre_tick && !sw_done);
      pre_half   = sw_start ? half_eff : half_q;
   end

   svd_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
      .clk(clk), .rst(rst), .run(run && sw_q), .load(pre_load),
      .half(pre_half), .plus_one(plus_next), .tick(pre_tick)
   );

   svd_swallow_ctl #(.PC_W(PC_W), .SC_W(SC_W)) u_ctl (
      .clk(clk), .rst(rst), .start(sw_start), .tick(pre_tick),
      .a_init(a_live), .b_init(pc_val), .done(sw_done), .plus_next(plus_next)
   );

   svd_direct_cnt #(.C_W(C_W)) u_dir (
      .clk(clk), .rst(rst), .start(dir_start), .run(run && !sw_q),
      .c_init({pc_val, sc_val}), .done(dir_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         arm_q     <= 1'b1;
         sw_q      <= 1'b0;
         half_q    <= 1'b0;
         syn_pulse <= 1'b0;
         cfg_err   <= 1'b0;
      end else if (stby) begin
         arm_q     <= 1'b1;
         syn_pulse <= 1'b0;
         cfg_err   <= 1'b0;
      end else begin
         syn_pulse <= period_end;
         if (start) begin
            arm_q   <= 1'b0;
            sw_q    <= live_sw;
            half_q  <= half_eff;
            cfg_err <= err_live;
         end
      end
   end
endmodule

// File: rtl/svd_checker.sv
module svd_checker (
   input logic       clk,
   input logic       rst,
   input logic [1:0] mode_sel,
   input logic       syn_pulse,
   input logic       cfg_err,
   input logic       arm_q,
   input logic       sw_q
);
   AST_STBY_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b00) |=> !syn_pulse); // R5

   AST_STBY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b00) |=> !cfg_err); // R5

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (syn_pulse && sw_q) |=> !syn_pulse); // R8

   AST_ERR_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
      (!rst && !arm_q && mode_sel != 2'b00) |=> (syn_pulse || $stable(cfg_err))); // R6
endmodule

bind vco_swallow_div svd_checker u_chk (
   .clk(clk), .rst(rst), .mode_sel(mode_sel), .syn_pulse(syn_pulse),
   .cfg_err(cfg_err), .arm_q(arm_q), .sw_q(sw_q)
);

// File: tb/vco_swallow_div_bench.sv
`timescale 1ns/1ps
module vco_swallow_div_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic [1:0] mode_sel;
   logic       half_step;
   logic [7:0] pc_val;
   logic [5:0] sc_val;
   logic       syn_pulse, cfg_err;
   int         n_run = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   vco_swallow_div u_vco_swallow_div (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .half_step(half_step),
      .pc_val(pc_val), .sc_val(sc_val), .syn_pulse(syn_pulse), .cfg_err(cfg_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_period(input logic [1:0] m, input logic h,
                                     input logic [7:0] pc, input logic [5:0] sc);
      int base, a, b, k;
      if (m == 2'b11) return int'({pc, sc}) + 1;
      base = h ? 32 : 64;
      a    = h ? int'(sc[4:0]) : int'(sc);
      b    = int'(pc);
      k    = (a < b + 1) ? a : b + 1;
      return (base + 1) * k + base * (b + 1 - k);
   endfunction

   function automatic int exp_err(input logic [1:0] m, input logic h,
                                  input logic [7:0] pc, input logic [5:0] sc);
      int base, a;
      if (m == 2'b11 || m == 2'b00) return 0;
      base = h ? 32 : 64;
      a    = h ? int'(sc[4:0]) : int'(sc);
      return (int'(pc) < a || int'(pc) < base || (h && sc[5])) ? 1 : 0;
   endfunction

   task automatic wait_pulse(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!syn_pulse && n < 40000);
   endtask

   // standby gap, then new settings; first pulse due N+1 falling edges later
   task automatic launch(input string req, input logic [1:0] m, input logic h,
                         input logic [7:0] pc, input logic [5:0] sc);
      int n;
      @(negedge clk);
      mode_sel = 2'b00;
      @(negedge clk);
      mode_sel = m; half_step = h; pc_val = pc; sc_val = sc;
      wait_pulse(n);
      check(req, n, exp_period(m, h, pc, sc) + 1);
      check({req, " err"}, int'(cfg_err), exp_err(m, h, pc, sc));
   endtask

   task automatic steady(input string req, input int exp);
      int n;
      wait_pulse(n);
      check(req, n, exp);
   endtask

   initial begin
      int cnt;
      void'($urandom(32'h5EED_0A1C));
      rst = 1'b1; mode_sel = 2'b00; half_step = 1'b0; pc_val = '0; sc_val = '0;
      repeat (3) @(negedge clk);
      check("R1 pulse in reset", int'(syn_pulse), 0);
      check("R1 err in reset", int'(cfg_err), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 pulse after reset", int'(syn_pulse), 0);
      check("R1 err after reset", int'(cfg_err), 0);

      // R2 full swallow
      launch("R2 fm 135/56", 2'b01, 1'b0, 8'd135, 6'd56);
      steady("R2 fm 135/56 steady", 8760);
      launch("R2 am A=0", 2'b10, 1'b0, 8'd70, 6'd0);
      launch("R2 am A=63 B=64", 2'b10, 1'b0, 8'd64, 6'd63);

      // R3 half swallow
      launch("R3 half 135/0", 2'b01, 1'b1, 8'd135, 6'd0);
      launch("R3 half 135/28", 2'b01, 1'b1, 8'd135, 6'd28);
      steady("R3 half 135/28 steady", 4380);
      launch("R3 half top bit ignored", 2'b10, 1'b1, 8'd135, 6'd60);

      // R4 direct
      launch("R4 direct 979", 2'b11, 1'b0, 8'd15, 6'd19);
      launch("R4 direct half ignored", 2'b11, 1'b1, 8'd15, 6'd19);
      steady("R4 direct steady", 980);
      launch("R4 direct C=0", 2'b11, 1'b0, 8'd0, 6'd0);
      steady("R4 direct C=0 steady", 1);

      // R7 error cases with defined period; R8 pulse width
      launch("R7 B<A", 2'b01, 1'b0, 8'd10, 6'd40);
      @(negedge clk);
      check("R8 pulse one cycle", int'(syn_pulse), 0);
      launch("R7 B<base", 2'b10, 1'b0, 8'd50, 6'd10);

      // R5 standby silences and clears error
      @(negedge clk);
      mode_sel = 2'b00;
      @(negedge clk);
      check("R5 err cleared", int'(cfg_err), 0);
      cnt = 0;
      repeat (300) begin
         @(negedge clk);
         if (syn_pulse) cnt++;
      end
      check("R5 no pulse in standby", cnt, 0);

      // R6 settings captured only at period boundary
      launch("R6 start", 2'b01, 1'b1, 8'd135, 6'd28);
      pc_val = 8'd100; sc_val = 6'd5;
      steady("R6 old period kept", 4380);
      steady("R6 new period", 32 * 100 + 5 + 32);
      mode_sel = 2'b11; pc_val = 8'd2; sc_val = 6'd0;
      steady("R6 mode held to boundary", 3237);
      steady("R6 direct after boundary", 129);

      // constrained random
      for (int i = 0; i < 8; i++) begin
         logic [1:0] m;
         logic       h;
         logic [7:0] pc;
         logic [5:0] sc;
         m = 2'($urandom_range(3, 1));
         h = 1'($urandom_range(1, 0));
         if (m == 2'b11) begin
            pc = 8'($urandom_range(7, 0));
            sc = 6'($urandom_range(63, 0));
            launch("R4 random", m, h, pc, sc);
         end else if (h) begin
            pc = 8'(32 + $urandom_range(12, 0));
            sc = 6'($urandom_range(31, 0));
            launch("R3 random", m, h, pc, sc);
         end else begin
            pc = 8'(56 + $urandom_range(20, 0));
            sc = 6'($urandom_range(63, 0));
            launch("R2 random", m, h, pc, sc);
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(190000 * 5);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule